// File: doc/BRIEF.md
# Store Ordering Violation Detector

When a store resolves its address, this block checks whether any younger load has already read from the same region of memory. The store brings with it the load-queue index it recorded at dispatch. The block walks the load queue from that index towards the current load tail, one entry per cycle. It compares the upper address bits of every load that has executed against the store's address.

The first executed load in walk order whose block address equals the store's is a load that ran too early. The block latches that load as the ordering violator and pulses a fault for the store. The latched violator stays visible until the consumer collects it with a read-and-clear strobe. While a violator is waiting to be collected, new stores are not checked. A store that writes no data is never checked.

The load queue is owned outside this block and is presented as flat arrays: entry `i` sits at bits `[i*W +: W]` of each array. The block does no recovery or squash of its own.

Top module: `ord_viol_det`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fault_o` and `viol_valid_o` are 0, and `viol_idx_o` and `viol_seq_o` are 0.
- R2: The walk covers the entries from `st_lq_idx_i` up to `lq_tail_i`, with the tail itself excluded. Entries outside that range never match, even if their address does. When the start index equals the tail, no entry is examined.
- R3: A load matches when `lq_exec_i[i]` is 1 and bits `[ADDR_W-1:BLK_SHIFT]` of its address equal those of the store address (`BLK_SHIFT` defaults to 8). Differences in the low `BLK_SHIFT` bits still match. A difference in any bit at or above `BLK_SHIFT` does not.
- R4: The first matching entry in walk order becomes the violator and ends the walk. `fault_o` pulses together with `done_o`, `viol_valid_o` rises, and `viol_idx_o`/`viol_seq_o` carry that entry's index and sequence number.
- R5: A load whose `lq_exec_i` bit is 0 never matches, whatever its address.
- R6: A walk that reaches the tail without a match ends with `done_o` pulsing and `fault_o` low. It leaves the violator register cleared: `viol_valid_o`, `viol_idx_o` and `viol_seq_o` are all 0.
- R7: While `viol_valid_o` is 1, a store request is ignored: `busy_o` stays 0 and the violator outputs keep their values.
- R8: A store request with `st_size_zero_i` = 1 is ignored: no walk starts and `busy_o` stays 0.
- R9: The violator outputs hold their values until `collect_i` is 1 for one cycle. After that edge, `viol_valid_o`, `viol_idx_o` and `viol_seq_o` read 0.
- R10: Suppose a request is accepted at edge E0 and the walk ends after examining the entry k positions past the start, or after finding the range empty (k = range length). Then `busy_o` is 1 from E0 until edge E(k+1), and `done_o` is high for exactly the one cycle after E(k+1).
- R11: Walk indices wrap from `LQ_DEPTH-1` to 0, so a range whose tail index is below its start index is scanned across the wrap.
- R12: A store request while `busy_o` is 1 is ignored. The running walk keeps the store address and tail it latched when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| st_req_i | input | 1 | Store address resolved, request a check |
| st_size_zero_i | input | 1 | Store writes no data; skip the check |
| st_addr_i | input | ADDR_W | Store address |
| st_lq_idx_i | input | IDX_W | Load-queue index recorded by the store at dispatch |
| lq_tail_i | input | IDX_W | Current load-queue tail |
| lq_exec_i | input | LQ_DEPTH | Per-entry flag: load has executed and holds a valid address |
| lq_addr_i | input | LQ_DEPTH*ADDR_W | Load addresses, entry i at [i*ADDR_W +: ADDR_W] |
| lq_seq_i | input | LQ_DEPTH*SEQ_W | Load sequence numbers, entry i at [i*SEQ_W +: SEQ_W] |
| collect_i | input | 1 | Read-and-clear strobe for the violator |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| fault_o | output | 1 | One-cycle pulse with done_o when a violation was found |
| viol_valid_o | output | 1 | A violator is latched and not yet collected |
| viol_idx_o | output | IDX_W | Load-queue index of the violator |
| viol_seq_o | output | SEQ_W | Sequence number of the violator |

## Verification
The bench builds the block with a six-entry load queue, 32-bit addresses, 16-bit sequence numbers and the default block shift of 8. A depth that is not a power of two makes the wrap from index 5 to 0 happen at the explicit limit rather than through a natural counter overflow. The short queue also lets a single walk cover the whole range, which is needed for latency checks over the full length and for tail-below-start ranges. The 8-bit shift places the boundary test between address bits 7 and 8.

// File: rtl/ovd_pkg.sv
package ovd_pkg;

  typedef enum logic {
    WS_IDLE = 1'b0,
    WS_SCAN = 1'b1
  } walk_state_e;

  // circular increment over a queue that need not be a power of two
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/ovd_entry_sel.sv
module ovd_entry_sel #(
  parameter int LQ_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int SEQ_W    = 16,
  parameter int IDX_W    = $clog2(LQ_DEPTH)
) (
  input  logic [LQ_DEPTH-1:0]        exec_i,
  input  logic [LQ_DEPTH*ADDR_W-1:0] addr_i,
  input  logic [LQ_DEPTH*SEQ_W-1:0]  seq_i,
  input  logic [IDX_W-1:0]           sel_i,
  output logic                       exec_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [SEQ_W-1:0]           seq_o
);

  logic [ADDR_W-1:0] addr_arr [LQ_DEPTH];
  logic [SEQ_W-1:0]  seq_arr  [LQ_DEPTH];

  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_unpack
    assign addr_arr[g] = addr_i[g*ADDR_W +: ADDR_W];
    assign seq_arr[g]  = seq_i[g*SEQ_W +: SEQ_W];
  end

  logic in_range;
  assign in_range = int'(sel_i) < LQ_DEPTH;

  always_comb begin
    exec_o = 1'b0;
    addr_o = '0;
    seq_o  = '0;
    if (in_range) begin
      exec_o = exec_i[sel_i];
      addr_o = addr_arr[sel_i];
      seq_o  = seq_arr[sel_i];
    end
  end

endmodule

// File: rtl/ovd_blk_cmp.sv
module ovd_blk_cmp #(
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  output logic              hit_o
);

  localparam int HI_W = ADDR_W - BLK_SHIFT;

  logic [HI_W-1:0] a_blk, b_blk;
  assign a_blk = a_i[ADDR_W-1:BLK_SHIFT];
  assign b_blk = b_i[ADDR_W-1:BLK_SHIFT];
  assign hit_o = en_i && (a_blk == b_blk);

endmodule

// File: rtl/ovd_walker.sv
module ovd_walker
  import ovd_pkg::*;
#(
  parameter int LQ_DEPTH = 8,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = $clog2(LQ_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_req_i,
  input  logic              st_size_zero_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [IDX_W-1:0]  st_lq_idx_i,
  input  logic [IDX_W-1:0]  lq_tail_i,
  input  logic              pend_i,
  input  logic              hit_i,
  output logic [IDX_W-1:0]  ptr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fault_o,
  output logic              set_o,
  output logic              clr_o
);

  walk_state_e       state_q;
  logic [IDX_W-1:0]  ptr_q, tail_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, fault_q;
  logic              accept, at_end, scanning;

  always_comb begin
    scanning = (state_q == WS_SCAN);
    accept   = (state_q == WS_IDLE) && st_req_i && !st_size_zero_i && !pend_i;
    at_end   = (ptr_q == tail_q);
    set_o    = scanning && !at_end && hit_i;
    clr_o    = scanning && at_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      ptr_q   <= '0;
      tail_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: begin
          if (accept) begin
            state_q <= WS_SCAN;
            ptr_q   <= st_lq_idx_i;
            tail_q  <= lq_tail_i;
            addr_q  <= st_addr_i;
          end
        end
        WS_SCAN: begin
          if (at_end || set_o) begin
            state_q <= WS_IDLE;
            done_q  <= 1'b1;
            fault_q <= set_o;
          end else begin
            ptr_q <= IDX_W'(wrap_inc(int'(ptr_q), LQ_DEPTH));
          end
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  assign ptr_o   = ptr_q;
  assign addr_o  = addr_q;
  assign busy_o  = scanning;
  assign done_o  = done_q;
  assign fault_o = fault_q;

  p_pending_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && st_req_i && pend_i) |=> !busy_o);

  p_zero_size_skip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && st_req_i && st_size_zero_i) |=> !busy_o);

  p_busy_end_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ptr_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(ptr_o) < LQ_DEPTH));

  p_addr_held_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_o));

endmodule

// File: rtl/ovd_viol_reg.sv
module ovd_viol_reg #(
  parameter int LQ_DEPTH = 8,
  parameter int SEQ_W    = 16,
  parameter int IDX_W    = $clog2(LQ_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SEQ_W-1:0] seq_i,
  input  logic             clr_i,
  input  logic             collect_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [SEQ_W-1:0] seq_o
);

  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      seq_q   <= '0;
    end else if (set_i) begin
      valid_q <= 1'b1;
      idx_q   <= idx_i;
      seq_q   <= seq_i;
    end else if (clr_i || collect_i) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      seq_q   <= '0;
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign seq_o   = seq_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !collect_i && !set_i && !clr_i) |=> (valid_o && $stable(idx_o) && $stable(seq_o)));

  p_collect_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (collect_i && !set_i) |=> (!valid_o && idx_o == '0 && seq_o == '0));

  p_no_match_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !valid_o);

endmodule

// File: rtl/ord_viol_det.sv
module ord_viol_det #(
  parameter int LQ_DEPTH  = 8,
  parameter int ADDR_W    = 32,
  parameter int SEQ_W     = 16,
  parameter int BLK_SHIFT = 8,
  localparam int IDX_W    = $clog2(LQ_DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       st_req_i,
  input  logic                       st_size_zero_i,
  input  logic [ADDR_W-1:0]          st_addr_i,
  input  logic [IDX_W-1:0]           st_lq_idx_i,
  input  logic [IDX_W-1:0]           lq_tail_i,
  input  logic [LQ_DEPTH-1:0]        lq_exec_i,
  input  logic [LQ_DEPTH*ADDR_W-1:0] lq_addr_i,
  input  logic [LQ_DEPTH*SEQ_W-1:0]  lq_seq_i,
  input  logic                       collect_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       fault_o,
  output logic                       viol_valid_o,
  output logic [IDX_W-1:0]           viol_idx_o,
  output logic [SEQ_W-1:0]           viol_seq_o
);

  logic [IDX_W-1:0]  ptr;
  logic [ADDR_W-1:0] walk_addr, ent_addr;
  logic [SEQ_W-1:0]  ent_seq;
  logic              ent_exec, ent_hit, set_v, clr_v;

  ovd_entry_sel #(
    .LQ_DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)
  ) u_sel (
    .exec_i(lq_exec_i), .addr_i(lq_addr_i), .seq_i(lq_seq_i), .sel_i(ptr),
    .exec_o(ent_exec), .addr_o(ent_addr), .seq_o(ent_seq)
  );

  ovd_blk_cmp #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_cmp (
    .en_i(ent_exec), .a_i(ent_addr), .b_i(walk_addr), .hit_o(ent_hit)
  );

  ovd_walker #(.LQ_DEPTH(LQ_DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .st_req_i(st_req_i), .st_size_zero_i(st_size_zero_i), .st_addr_i(st_addr_i),
    .st_lq_idx_i(st_lq_idx_i), .lq_tail_i(lq_tail_i),
    .pend_i(viol_valid_o), .hit_i(ent_hit),
    .ptr_o(ptr), .addr_o(walk_addr), .busy_o(busy_o), .done_o(done_o),
    .fault_o(fault_o), .set_o(set_v), .clr_o(clr_v)
  );

  ovd_viol_reg #(.LQ_DEPTH(LQ_DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_viol (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(set_v), .idx_i(ptr), .seq_i(ent_seq), .clr_i(clr_v), .collect_i(collect_i),
    .valid_o(viol_valid_o), .idx_o(viol_idx_o), .seq_o(viol_seq_o)
  );

  p_fault_sets_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> viol_valid_o);

  p_fault_with_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);

  p_unexec_no_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !lq_exec_i[ptr]) |=> !fault_o);

endmodule

// File: tb/sim_ord_viol_det.sv
module sim_ord_viol_det;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 6;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int IW = $clog2(D);

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_req = 0, st_zero = 0, collect = 0;
  logic [AW-1:0] st_addr = '0;
  logic [IW-1:0] st_idx = '0, lq_tail = '0;
  logic [D-1:0] lq_exec = '0;
  logic [D-1:0][AW-1:0] lq_addr = '0;
  logic [D-1:0][SW-1:0] lq_seq = '0;
  logic busy_o, done_o, fault_o, viol_valid_o;
  logic [IW-1:0] viol_idx_o;
  logic [SW-1:0] viol_seq_o;

  ord_viol_det #(.LQ_DEPTH(D), .ADDR_W(AW), .SEQ_W(SW), .BLK_SHIFT(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .st_req_i(st_req), .st_size_zero_i(st_zero),
    .st_addr_i(st_addr), .st_lq_idx_i(st_idx), .lq_tail_i(lq_tail),
    .lq_exec_i(lq_exec), .lq_addr_i(lq_addr), .lq_seq_i(lq_seq),
    .collect_i(collect), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .viol_valid_o(viol_valid_o), .viol_idx_o(viol_idx_o), .viol_seq_o(viol_seq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit    fault;
    int    idx;
    int    seq;
    int    lat;
    int    issue;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: pops one expectation per done pulse
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done_o) begin
      if (sbq.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        e = sbq.pop_front();
        chk(fault_o == e.fault, e.tag, "fault", fault_o, e.fault);
        chk(viol_valid_o == e.fault, e.tag, "viol_valid", viol_valid_o, e.fault);
        chk(int'(viol_idx_o) == e.idx, e.tag, "viol_idx", viol_idx_o, e.idx);
        chk(int'(viol_seq_o) == e.seq, e.tag, "viol_seq", viol_seq_o, e.seq);
        chk(cyc - e.issue == e.lat + 1, e.tag, "latency", cyc - e.issue, e.lat + 1);
      end
    end
  end

  function automatic exp_t model(int start, int tail, logic [AW-1:0] a, string tag);
    exp_t e;
    int i = start;
    int k = 0;
    e.fault = 0; e.idx = 0; e.seq = 0; e.tag = tag; e.issue = 0;
    while (i != tail) begin
      if (lq_exec[i] && (lq_addr[i][AW-1:8] == a[AW-1:8])) begin
        e.fault = 1; e.idx = i; e.seq = int'(lq_seq[i]); e.lat = k + 1;
        return e;
      end
      i = (i + 1) % D;
      k++;
    end
    e.lat = k + 1;
    return e;
  endfunction

  task automatic clear_all();
    lq_exec = '0;
    lq_addr = '0;
  endtask

  task automatic set_entry(int i, bit ex, logic [AW-1:0] a);
    lq_exec[i] = ex;
    lq_addr[i] = a;
  endtask

  task automatic wait_drain(string tag);
    for (int w = 0; w < 40 && sbq.size() != 0; w++) @(negedge clk);
    if (sbq.size() != 0) begin
      chk(0, tag, "no done", 0, 1);
      sbq.delete();
    end
  endtask

  // driver: pushes the expected result, then issues the store
  task automatic run_store(int start, int tail, logic [AW-1:0] a, string tag);
    exp_t e;
    e = model(start, tail, a, tag);
    @(negedge clk);
    st_req = 1; st_zero = 0; st_addr = a;
    st_idx = IW'(start); lq_tail = IW'(tail);
    e.issue = cyc;
    sbq.push_back(e);
    @(negedge clk);
    st_req = 0;
    chk(busy_o == 1'b1, "R10", "busy after accept", busy_o, 1);
    wait_drain(tag);
  endtask

  task automatic ignored_store(int start, int tail, logic [AW-1:0] a, bit zero, string tag);
    logic vv; logic [IW-1:0] vi; logic [SW-1:0] vs;
    vv = viol_valid_o; vi = viol_idx_o; vs = viol_seq_o;
    @(negedge clk);
    st_req = 1; st_zero = zero; st_addr = a;
    st_idx = IW'(start); lq_tail = IW'(tail);
    @(negedge clk);
    st_req = 0; st_zero = 0;
    chk(busy_o == 1'b0, tag, "busy on ignored store", busy_o, 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, tag, "busy later", busy_o, 0);
    chk(viol_valid_o == vv, tag, "viol_valid unchanged", viol_valid_o, vv);
    chk(viol_idx_o == vi && viol_seq_o == vs, tag, "violator unchanged",
        {viol_idx_o, viol_seq_o}, {vi, vs});
  endtask

  task automatic collect_viol();
    repeat (2) @(negedge clk);
    chk(viol_valid_o == 1'b1, "R9", "held before collect", viol_valid_o, 1);
    collect = 1;
    @(negedge clk);
    collect = 0;
    chk(viol_valid_o == 1'b0, "R9", "valid after collect", viol_valid_o, 0);
    chk(viol_idx_o == '0 && viol_seq_o == '0, "R9", "fields after collect",
        {viol_idx_o, viol_seq_o}, 0);
  endtask

  localparam logic [AW-1:0] A = 32'h1234_5600;

  initial begin
    for (int i = 0; i < D; i++) lq_seq[i] = SW'(16'h0A00 + i * 3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && done_o == 0 && fault_o == 0, "R1", "ctl at reset",
        {busy_o, done_o, fault_o}, 0);
    chk(viol_valid_o == 0 && viol_idx_o == 0 && viol_seq_o == 0, "R1", "violator at reset",
        {viol_valid_o, viol_idx_o, viol_seq_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 hit at the start entry
    clear_all(); set_entry(1, 1, A + 32'h10);
    run_store(1, 4, A, "R2");
    collect_viol();

    // R3 low bits ignored
    clear_all();
    set_entry(0, 1, 32'h0000_1000); set_entry(1, 1, 32'hFFFF_0000); set_entry(2, 1, 32'h1234_56FF);
    run_store(0, 3, A, "R3");
    collect_viol();

    // R3/R6 bit 8 and top bit differ: no match, register cleared
    clear_all();
    set_entry(0, 1, 32'h1234_5700); set_entry(1, 1, 32'h1234_5500); set_entry(2, 1, 32'h9234_5600);
    run_store(0, 3, A, "R6");

    // R4 first match wins
    clear_all(); set_entry(2, 1, A); set_entry(3, 1, A + 1);
    run_store(1, 5, A, "R4");
    collect_viol();

    // R5 unexecuted loads skipped
    clear_all(); set_entry(1, 0, A); set_entry(2, 1, A + 4);
    run_store(1, 4, A, "R5");
    collect_viol();
    clear_all(); set_entry(1, 0, A);
    run_store(1, 2, A, "R5");

    // R2 matches outside the range ignored
    clear_all(); set_entry(0, 1, A); set_entry(3, 1, A);
    run_store(1, 3, A, "R2");

    // R11 wrap-around
    clear_all(); set_entry(0, 1, A); set_entry(5, 1, 32'h1234_5800);
    run_store(4, 2, A, "R11");
    collect_viol();

    // R10 empty range
    clear_all(); set_entry(3, 1, A);
    run_store(3, 3, A, "R10");

    // R7 pending violator blocks a new check
    clear_all(); set_entry(2, 1, A);
    run_store(2, 4, A, "R7");
    ignored_store(2, 4, A, 0, "R7");
    collect_viol();

    // R8 zero-size store skipped
    ignored_store(2, 4, A, 1, "R8");

    // R12 request during a walk ignored
    clear_all(); set_entry(3, 1, 32'h5555_0000); set_entry(4, 1, A);
    begin
      exp_t e;
      e = model(0, 5, A, "R12");
      @(negedge clk);
      st_req = 1; st_addr = A; st_idx = 0; lq_tail = 5;
      e.issue = cyc;
      sbq.push_back(e);
      @(negedge clk);
      st_req = 0;
      @(negedge clk);
      st_req = 1; st_addr = 32'h5555_0000; st_idx = 3; lq_tail = 4;
      @(negedge clk);
      st_req = 0;
      wait_drain("R12");
    end
    collect_viol();

    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 1);
    summary();
  end

endmodule